// File: doc/BRIEF.md
# Double-Buffered DAC Command Controller

This block sits between a serial word receiver and a resistor-string converter. Each received 24-bit word carries an 8-bit control byte in bits 23..16 and a 16-bit data field in bits 15..0. The block decodes the word and keeps two code registers. The staging register is loaded by write commands. The output register drives the converter code. It also holds three control flags: power-down, ready-enable and linearity-optimise.

The output register can take a new value in three ways: a write-through command, a software load command, or an active-low hardware load pin. The load pin is asynchronous and passes through a synchronizer. While the pin is held low, the staging register is transparent, so every write reaches the output register directly. A software clear restores the full reset state. The restore code for the output register then depends on a select pin: zero when the pin is low, midscale when it is high. A parameter narrows the code to 12 bits, taken from data bits 15..4.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset the staging register is 0. The output code is 0 when mid_sel is low and midscale (1 followed by zeros) when it is high. pwr_down is 0, rdy_en is 1 and lin_opt is 0.
- R2: Control byte 0x10 loads the data code into the staging register only. dac_code does not change.
- R3: Control byte 0x30 loads the data code into both registers. dac_code shows it on the next clock.
- R4: Control byte 0x01 copies the staging register to the output register when data bit 8 is 1. When data bit 8 is 0, dac_code is left unchanged.
- R5: Control byte 0x02 restores every register and flag to the values of R1. The output code is chosen by mid_sel as it stands at the time of the command.
- R6: Control byte 0x03 sets pwr_down from data bit 8 and rdy_en from data bit 7. dac_code keeps its value.
- R7: Control byte 0x05 sets lin_opt from data bit 8.
- R8: While the synchronized load_n is low, the output register follows the staging register. A 0x10 write made during that time reaches dac_code on the same clock as the staging register.
- R9: Control bytes 0x00 and 0x20, and every byte not listed here, change no register and no flag.
- R10: With CODE_W = 12, the code is data bits 15..4 and midscale is 0x800. Data bits 3..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A received word is present for one cycle |
| cmd_word | input | 24 | Control byte in bits 23..16, data field in bits 15..0 |
| load_n | input | 1 | Asynchronous active-low hardware load |
| mid_sel | input | 1 | Restore code select: 0 gives zero, 1 gives midscale |
| dac_code | output | CODE_W | Output register code for the converter |
| pwr_down | output | 1 | Converter power-down flag |
| rdy_en | output | 1 | Ready-output enable flag |
| lin_opt | output | 1 | Linearity-optimise flag |

## Verification
The assertions assume that cmd_valid is a single-cycle strobe. They also assume that mid_sel does not change in the cycle of a clear, and that load_n stays at one level long enough to pass the two synchronizer stages. The stimulus drives every input on the falling clock edge. It changes mid_sel only while no command is pending. Between a change of load_n and the next check it waits four cycles, so the synchronizer has settled before the output is sampled.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int CTRL_W   = 8;
  localparam int DATA_W   = 16;
  localparam int WORD_W   = CTRL_W + DATA_W;
  localparam int FLAG_BIT = 8;
  localparam int RDY_BIT  = 7;

  typedef enum logic [CTRL_W-1:0] {
    OP_IDLE  = 8'h00,
    OP_LOAD  = 8'h01,
    OP_CLEAR = 8'h02,
    OP_POWER = 8'h03,
    OP_LIN   = 8'h05,
    OP_STAGE = 8'h10,
    OP_IDLE2 = 8'h20,
    OP_THRU  = 8'h30
  } op_e;

  typedef struct packed {
    logic wr_in;
    logic wr_dac;
    logic sw_load;
    logic clr;
    logic pwr;
    logic lin;
  } strobe_t;

  function automatic strobe_t decode_op(input logic [CTRL_W-1:0] ctrl,
                                        input logic [DATA_W-1:0] data);
    strobe_t s;
    s = '0;
    case (ctrl)
      OP_LOAD:  s.sw_load = data[FLAG_BIT];
      OP_CLEAR: s.clr     = 1'b1;
      OP_POWER: s.pwr     = 1'b1;
      OP_LIN:   s.lin     = 1'b1;
      OP_STAGE: s.wr_in   = 1'b1;
      OP_THRU:  begin s.wr_in = 1'b1; s.wr_dac = 1'b1; end
      default:  s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output strobe_t           stb,
  output logic [DATA_W-1:0] data
);
  logic [CTRL_W-1:0] ctrl;

  assign ctrl = cmd_word[WORD_W-1 -: CTRL_W];
  assign data = cmd_word[DATA_W-1:0];

  always_comb begin
    stb = '0;
    if (cmd_valid) stb = decode_op(ctrl, data);
  end
endmodule

// File: rtl/dac_load_sync.sv
module dac_load_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  output logic hold
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], load_n};
  end

  assign hold = ~sh[STAGES-1];
endmodule

// File: rtl/dac_reg_pair.sv
module dac_reg_pair
  import dac_cmd_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mid_sel,
  input  logic              hold,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] dac_code
);
  localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] in_reg;
  logic [CODE_W-1:0] code_in;
  logic [CODE_W-1:0] rst_val;

  function automatic logic [CODE_W-1:0] pick_code(input logic [DATA_W-1:0] d);
    return d[DATA_W-1 -: CODE_W];
  endfunction

  assign code_in = pick_code(data);
  assign rst_val = mid_sel ? MIDSCALE : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reg   <= '0;
      dac_code <= rst_val;
    end else if (stb.clr) begin
      in_reg   <= '0;
      dac_code <= rst_val;
    end else begin
      if (stb.wr_in) in_reg <= code_in;
      if (stb.wr_dac || (hold && stb.wr_in)) dac_code <= code_in;
      else if (hold || stb.sw_load)          dac_code <= in_reg;
    end
  end

  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wr_in && !stb.wr_dac && !hold) |=> $stable(dac_code));
  p_thru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wr_dac |=> (dac_code == $past(code_in)));
  p_swload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.sw_load && !stb.clr) |=> (dac_code == $past(in_reg)));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clr |=> (in_reg == '0 && dac_code == $past(rst_val)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !stb.wr_in && !stb.clr) |=> (dac_code == $past(in_reg)));
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [23:0]       cmd_word,
  input  logic              load_n,
  input  logic              mid_sel,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              rdy_en,
  output logic              lin_opt
);
  strobe_t           stb;
  logic [DATA_W-1:0] data;
  logic              hold;

  dac_cmd_decode u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .stb(stb), .data(data)
  );

  dac_load_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .hold(hold)
  );

  dac_reg_pair #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .hold(hold),
    .stb(stb), .data(data), .dac_code(dac_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_down <= 1'b0;
      rdy_en   <= 1'b1;
      lin_opt  <= 1'b0;
    end else if (stb.clr) begin
      pwr_down <= 1'b0;
      rdy_en   <= 1'b1;
      lin_opt  <= 1'b0;
    end else begin
      if (stb.pwr) begin
        pwr_down <= data[FLAG_BIT];
        rdy_en   <= data[RDY_BIT];
      end
      if (stb.lin) lin_opt <= data[FLAG_BIT];
    end
  end

  p_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pwr |=> (pwr_down == $past(cmd_word[FLAG_BIT]) && rdy_en == $past(cmd_word[RDY_BIT])));
  p_power_keeps_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.pwr && !hold) |=> $stable(dac_code));
  p_lin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.lin |=> (lin_opt == $past(cmd_word[FLAG_BIT])));
  p_flags_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(pwr_down) && $stable(rdy_en) && $stable(lin_opt)));
endmodule

// File: tb/tb_dac_cmd_ctrl.sv
module tb_dac_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic        load_n = 1'b1;
  logic        mid_sel = 1'b1;
  logic [15:0] code16;
  logic [11:0] code12;
  logic        pd, rdy, lin, pd12, rdy12, lin12;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dac_cmd_ctrl #(.CODE_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .load_n(load_n), .mid_sel(mid_sel), .dac_code(code16),
    .pwr_down(pd), .rdy_en(rdy), .lin_opt(lin)
  );

  dac_cmd_ctrl #(.CODE_W(12)) dut_n12 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .load_n(load_n), .mid_sel(mid_sel), .dac_code(code12),
    .pwr_down(pd12), .rdy_en(rdy12), .lin_opt(lin12)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] ctrl, input logic [15:0] data);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {ctrl, data};
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 code", code16, 16'h8000);
    check("R1 code12", code12, 12'h800);
    check("R1 flags", {pd, rdy, lin}, 3'b010);
    send(8'h01, 16'h0100);
    check("R1 staging zero", code16, 16'h0000);
  endtask

  task automatic t_stage_and_load();
    send(8'h10, 16'h1234);
    check("R2 output unchanged", code16, 16'h0000);
    send(8'h01, 16'hFEFF);
    check("R4 flag clear no copy", code16, 16'h0000);
    send(8'h01, 16'h0100);
    check("R4 copy", code16, 16'h1234);
  endtask

  task automatic t_thru();
    send(8'h30, 16'hABCD);
    check("R3 thru", code16, 16'hABCD);
    check("R10 narrow thru", code12, 12'hABC);
  endtask

  task automatic t_power();
    send(8'h03, 16'h0100);
    check("R6 pd on rdy off", {pd, rdy}, 2'b10);
    check("R6 code kept", code16, 16'hABCD);
    send(8'h03, 16'h0080);
    check("R6 pd off rdy on", {pd, rdy}, 2'b01);
  endtask

  task automatic t_lin();
    send(8'h05, 16'h0100);
    check("R7 lin set", lin, 1'b1);
    send(8'h05, 16'hFEFF);
    check("R7 lin clear", lin, 1'b0);
  endtask

  task automatic t_ignore();
    send(8'h10, 16'h5555);
    send(8'h00, 16'hFFFF);
    send(8'h20, 16'hFFFF);
    send(8'h7F, 16'hFFFF);
    send(8'h04, 16'hFFFF);
    check("R9 code", code16, 16'hABCD);
    check("R9 flags", {pd, rdy, lin}, 3'b010);
    send(8'h01, 16'h0100);
    check("R9 staging kept", code16, 16'h5555);
  endtask

  task automatic t_hw_load();
    send(8'h10, 16'h0F0F);
    check("R8 before load", code16, 16'h5555);
    load_n = 1'b0;
    idle(4);
    check("R8 pin load", code16, 16'h0F0F);
    send(8'h10, 16'h7777);
    check("R8 transparent", code16, 16'h7777);
    load_n = 1'b1;
    idle(4);
    send(8'h10, 16'h1111);
    check("R8 released", code16, 16'h7777);
  endtask

  task automatic t_clear();
    send(8'h03, 16'h0100);
    send(8'h05, 16'h0100);
    mid_sel = 1'b0;
    send(8'h02, 16'h0000);
    check("R5 zero code", code16, 16'h0000);
    check("R5 flags", {pd, rdy, lin}, 3'b010);
    send(8'h01, 16'h0100);
    check("R5 staging cleared", code16, 16'h0000);
    mid_sel = 1'b1;
    send(8'h02, 16'h0000);
    check("R5 midscale", code16, 16'h8000);
    check("R10 midscale", code12, 12'h800);
    send(8'h30, 16'h123F);
    check("R10 low bits ignored", code12, 12'h123);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_stage_and_load();
    t_thru();
    t_power();
    t_lin();
    t_ignore();
    t_hw_load();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule